// File: doc/BRIEF.md
# DDR 4:2:2 Video Input Deinterleaver

This block takes an 8-bit video bus that runs at double data rate. One edge of the clock carries luma, and the other edge carries chroma that alternates between Cb and Cr. The block samples the bus on both edges of the clock and brings every sample into the rising-edge domain. Each chroma sample is paired with the luma sample that follows it in time. The result is one pixel per rising edge: a luma byte, a chroma byte, a flag that says whether the chroma is Cr, and a valid strobe.

A two-bit select input sets which clock edge carries luma. The block also watches the stream for embedded timing reference codes. Such a code is the byte run FF, 00, 00 followed by a status word. When the block finds one, it removes the four bytes from the pixel stream, decodes the field, vertical-blank and SAV/EAV bits of the status word onto held output flags, and restarts the chroma alternation at Cb.

Top module: `ddr422_deinterleave`

## Requirements
- R1: While `rst_n` is low, every output is 0. After reset is released, `pix_valid` stays low until the first pair has passed through the pipeline.
- R2: With `luma_edge_sel` = 2'b11, luma is sampled on the rising edge and chroma on the falling edge. A pixel pairs each falling-edge chroma sample with the rising-edge luma sample that comes after it.
- R3: With `luma_edge_sel` = 2'b00, chroma is sampled on the rising edge and luma on the falling edge of the same clock cycle. Each pixel pairs those two samples.
- R4: The select values 2'b01 and 2'b10 behave exactly like 2'b00.
- R5: The first valid pixel after reset carries Cb (`pix_c_is_cr` = 0). `pix_c_is_cr` toggles on every later valid pixel, and 1 means Cr.
- R6: A timing reference is detected when a pair with chroma FF and luma 00 is followed by a pair with chroma 00 whose luma has bit 7 set. Neither of the two pairs produces a valid pixel.
- R7: `trs_seen` pulses for one cycle in the slot of the status-word pair. `trs_field`, `trs_vblank` and `trs_eav` take status-word bits 6, 5 and 4 and hold them until the next detection.
- R8: After a detected timing reference, the next valid pixel is Cb, even when an odd number of pixels came before the reference.
- R9: A partial match produces ordinary pixels and restarts the matcher. Partial matches include: a wrong second or third byte, a status word with bit 7 clear, or FF,00 repeated before the 00.
- R10: Every non-reference pair comes out in order, one per rising edge, with no loss. The pair whose chroma is sampled first after release is valid on the fourth rising edge after reset release.
- R11: Bytes pass through bit for bit, with bus bit 0 as the LSB of both `pix_y` and `pix_c`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; both edges sample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| luma_edge_sel | input | 2 | 2'b11: luma on rising edge; any other value: luma on falling edge |
| ddr_data | input | DW | Double-data-rate luma/chroma bus, bit 0 is LSB |
| pix_y | output | DW | Luma of the output pixel |
| pix_c | output | DW | Chroma (Cb or Cr) of the output pixel |
| pix_c_is_cr | output | 1 | 1 when `pix_c` is Cr, 0 when Cb |
| pix_valid | output | 1 | Pixel outputs hold a video sample |
| trs_seen | output | 1 | One-cycle pulse for a detected timing reference |
| trs_field | output | 1 | Field bit of the last status word |
| trs_vblank | output | 1 | Vertical-blank bit of the last status word |
| trs_eav | output | 1 | 1 for end of active video, 0 for start |

## Verification
The hardest situations to reach are near-miss preambles, where a reference almost completes but fails in its final pair, and chroma-phase restarts after an odd number of pixels. Both depend on the exact byte order on alternating clock edges. The bench therefore builds each stream as a plain byte list of chroma/luma pairs. These include all eight status-bit combinations, each after three pixels, as well as repeated FF,00 pairs, wrong bytes and status words with bit 7 clear. A driver then places every byte on the edge that the active select value assigns to it. A byte-level model of the stream gives the expected pixel list, the Cb/Cr order and the decoded flags for each select value.

// File: rtl/ddr422_deinterleave.sv
module ddr422_deinterleave #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    luma_edge_sel,
  input  logic [DW-1:0] ddr_data,
  output logic [DW-1:0] pix_y,
  output logic [DW-1:0] pix_c,
  output logic          pix_c_is_cr,
  output logic          pix_valid,
  output logic          trs_seen,
  output logic          trs_field,
  output logic          trs_vblank,
  output logic          trs_eav
);

  localparam logic [DW-1:0] ALL_ONES = '1;
  localparam logic [DW-1:0] ALL_ZERO = '0;

  logic [DW-1:0] fall_q, rise_q;
  logic [DW-1:0] pair_c, pair_y;
  logic [DW-1:0] s1_c, s1_y, s2_c, s2_y;
  logic          luma_on_rise;
  logic          primed, s1_v, s2_v, xy_pend, det, emit, cr_phase;

  always_ff @(negedge clk) fall_q <= ddr_data;
  always_ff @(posedge clk) rise_q <= ddr_data;

  assign luma_on_rise = (luma_edge_sel == 2'b11);
  assign pair_c = luma_on_rise ? fall_q   : rise_q;
  assign pair_y = luma_on_rise ? ddr_data : fall_q;

  always_ff @(posedge clk) begin
    s1_c <= pair_c;
    s1_y <= pair_y;
    s2_c <= s1_c;
    s2_y <= s1_y;
  end

  assign det = s2_v && s1_v &&
               (s2_c == ALL_ONES) && (s2_y == ALL_ZERO) &&
               (s1_c == ALL_ZERO) && s1_y[DW-1];

  assign emit = s2_v && !det && !xy_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed  <= 1'b0;
      s1_v    <= 1'b0;
      s2_v    <= 1'b0;
      xy_pend <= 1'b0;
    end else begin
      primed  <= 1'b1;
      s1_v    <= primed;
      s2_v    <= s1_v;
      xy_pend <= det;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_y       <= '0;
      pix_c       <= '0;
      pix_c_is_cr <= 1'b0;
      pix_valid   <= 1'b0;
      cr_phase    <= 1'b0;
      trs_seen    <= 1'b0;
      trs_field   <= 1'b0;
      trs_vblank  <= 1'b0;
      trs_eav     <= 1'b0;
    end else begin
      pix_y       <= s2_y;
      pix_c       <= s2_c;
      pix_c_is_cr <= cr_phase;
      pix_valid   <= emit;
      trs_seen    <= xy_pend;
      if (emit) cr_phase <= ~cr_phase;
      if (xy_pend) begin
        cr_phase   <= 1'b0;
        trs_field  <= s2_y[DW-2];
        trs_vblank <= s2_y[DW-3];
        trs_eav    <= s2_y[DW-4];
      end
    end
  end

endmodule

// File: rtl/ddr422_deinterleave_chk.sv
module ddr422_deinterleave_chk (
  input logic clk,
  input logic rst_n,
  input logic pix_valid,
  input logic pix_c_is_cr,
  input logic trs_seen,
  input logic trs_field,
  input logic trs_vblank,
  input logic trs_eav
);

  logic after_trs;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         after_trs <= 1'b0;
    else if (trs_seen)  after_trs <= 1'b1;
    else if (pix_valid) after_trs <= 1'b0;
  end

  // R5
  cr_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && $past(pix_valid)) |-> (pix_c_is_cr != $past(pix_c_is_cr)));

  // R8
  cb_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && after_trs) |-> !pix_c_is_cr);

  // R7
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trs_seen |-> $stable({trs_field, trs_vblank, trs_eav}));

  // R6
  trs_novalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trs_seen |-> (!pix_valid && !$past(pix_valid)));

  // R7
  trs_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trs_seen |=> !trs_seen);

endmodule

bind ddr422_deinterleave ddr422_deinterleave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_c_is_cr(pix_c_is_cr),
  .trs_seen(trs_seen), .trs_field(trs_field), .trs_vblank(trs_vblank),
  .trs_eav(trs_eav)
);

// File: tb/test_ddr422_deinterleave.sv
`timescale 1ns/1ps
module test_ddr422_deinterleave;
  localparam int MAXB = 512;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] sel = 2'b00;
  logic [7:0] din = 8'h10;
  logic [7:0] pix_y, pix_c;
  logic       pix_c_is_cr, pix_valid, trs_seen, trs_field, trs_vblank, trs_eav;

  ddr422_deinterleave #(.DW(8)) i_ddr422_deinterleave (
    .clk(clk), .rst_n(rst_n), .luma_edge_sel(sel), .ddr_data(din),
    .pix_y(pix_y), .pix_c(pix_c), .pix_c_is_cr(pix_c_is_cr),
    .pix_valid(pix_valid), .trs_seen(trs_seen), .trs_field(trs_field),
    .trs_vblank(trs_vblank), .trs_eav(trs_eav)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int fails = 0;

  logic [7:0] sb [MAXB];
  int         nb;
  logic [7:0] ey [MAXB];
  logic [7:0] ec [MAXB];
  logic       ecr [MAXB];
  int         en;
  logic [7:0] exy [64];
  int         ent;
  logic [7:0] oy [MAXB];
  logic [7:0] oc [MAXB];
  logic       ocr [MAXB];
  int         obs_n;
  logic [2:0] otf [64];
  int         otn;
  int         first_edge;
  int         edge_cnt;
  bit         mon_en = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always begin
    @(posedge clk); #1;
    if (mon_en) begin
      edge_cnt++;
      if (pix_valid) begin
        if (first_edge < 0) first_edge = edge_cnt;
        if (obs_n < MAXB) begin
          oy[obs_n] = pix_y; oc[obs_n] = pix_c; ocr[obs_n] = pix_c_is_cr;
        end
        obs_n++;
      end
      if (trs_seen) begin
        if (otn < 64) otf[otn] = {trs_field, trs_vblank, trs_eav};
        otn++;
      end
    end
  end

  task automatic put(input logic [7:0] c, input logic [7:0] y);
    sb[nb] = c; sb[nb+1] = y; nb += 2;
  endtask

  task automatic build(input int pat);
    nb = 0;
    case (pat)
      0: for (int j = 0; j < 40; j++) put(8'(j*37+5), 8'(j*53+11));
      1: for (int k = 0; k < 8; k++) begin
           for (int j = 0; j < 3; j++) put(8'(k*16+j+1), 8'(k*9+j+40));
           put(8'hFF, 8'h00);
           put(8'h00, 8'(128 + k*16 + k));
         end
      2: begin
           put(8'hFF, 8'h00); put(8'h00, 8'h7F);
           put(8'h21, 8'h42);
           put(8'hFF, 8'h01); put(8'h00, 8'h80);
           put(8'hFF, 8'h00); put(8'h01, 8'h80);
           put(8'hFE, 8'h00); put(8'h00, 8'h80);
           put(8'hFF, 8'h00); put(8'hFF, 8'h00); put(8'h00, 8'h9D);
           put(8'h33, 8'h44);
           put(8'hFF, 8'h00); put(8'h00, 8'hB0);
           put(8'hFF, 8'h00); put(8'h00, 8'hF0);
           for (int j = 0; j < 5; j++) put(8'(j+100), 8'(j+200));
         end
      default: for (int j = 0; j < 128; j++) put(8'(2*j), 8'(2*j+1));
    endcase
    for (int j = 0; j < 4; j++) put(8'h80, 8'h10);
  endtask

  task automatic model();
    int   np;
    int   j;
    logic ph;
    np = nb / 2; j = 0; ph = 1'b0; en = 0; ent = 0;
    while (j < np) begin
      if (j + 1 < np && sb[2*j] == 8'hFF && sb[2*j+1] == 8'h00 &&
          sb[2*j+2] == 8'h00 && sb[2*j+3][7]) begin
        exy[ent] = sb[2*j+3]; ent++; ph = 1'b0; j += 2;
      end else begin
        ec[en] = sb[2*j]; ey[en] = sb[2*j+1]; ecr[en] = ph;
        ph = ~ph; en++; j++;
      end
    end
  endtask

  task automatic drive();
    int total;
    logic [7:0] v;
    total = (sel == 2'b11) ? nb + 1 : nb;
    for (int s = 0; s < total; s++) begin
      if (sel == 2'b11) v = (s == 0) ? 8'h10 : sb[s-1];
      else              v = sb[s];
      if (s % 2 == 0) begin @(negedge clk); #1; end
      else            begin @(posedge clk); #1; end
      if (s == 0) begin
        rst_n = 1'b1; mon_en = 1'b1;
      end
      din = v;
    end
  endtask

  task automatic run(input logic [1:0] s, input int pat);
    string dtag, ctag, ntag;
    rst_n = 1'b0; mon_en = 1'b0; sel = s; din = 8'h10;
    build(pat); model();
    repeat (3) @(posedge clk); #1;
    chk({pix_valid, pix_c_is_cr, trs_seen, trs_field, trs_vblank, trs_eav} == 6'd0,
        "R1", "flags in reset", {pix_valid, pix_c_is_cr, trs_seen, trs_field, trs_vblank, trs_eav}, 0);
    chk(pix_y == 8'd0 && pix_c == 8'd0, "R1", "data in reset", {pix_y, pix_c}, 0);
    obs_n = 0; otn = 0; first_edge = -1; edge_cnt = 0;
    drive();
    repeat (8) @(posedge clk); #1;
    mon_en = 1'b0;
    dtag = (pat == 3) ? "R11" : (s == 2'b11) ? "R2" : (s == 2'b00) ? "R3" : "R4";
    ctag = (pat == 1) ? "R8" : "R5";
    ntag = (pat == 2) ? "R9" : (pat == 1) ? "R6" : "R10";
    chk(first_edge == 4, "R10", "first valid edge", first_edge, 4);
    chk(obs_n >= en, ntag, "pixel count", obs_n, en);
    for (int i = 0; i < en && i < obs_n && i < MAXB; i++) begin
      chk(oy[i] == ey[i], dtag, "luma", oy[i], ey[i]);
      chk(oc[i] == ec[i], dtag, "chroma", oc[i], ec[i]);
      chk(ocr[i] == ecr[i], ctag, "cr flag", ocr[i], ecr[i]);
    end
    chk(otn == ent, "R6", "reference count", otn, ent);
    for (int i = 0; i < ent && i < otn; i++)
      chk(otf[i] == exy[i][6:4], "R7", "status bits", otf[i], exy[i][6:4]);
    if (ent > 0)
      chk({trs_field, trs_vblank, trs_eav} == exy[ent-1][6:4], "R7", "held flags",
          {trs_field, trs_vblank, trs_eav}, exy[ent-1][6:4]);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [1:0] sels [4];
    sels[0] = 2'b00; sels[1] = 2'b11; sels[2] = 2'b01; sels[3] = 2'b10;
    for (int si = 0; si < 4; si++)
      for (int p = 0; p < 4; p++)
        run(sels[si], p);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule